// File: doc/BRIEF.md
# Octree Locational Code Unit

This block does the index arithmetic that a hashed (linear) octree needs when it walks its nodes. A node is named by a locational code. The code is a string of 3-bit octant numbers running from the root down to the node. Above the most significant octant sits one extra 1 bit, which marks where the string starts. The root therefore has the code 1. With this marker, the depth of any node follows from the position of its highest set bit.

A request carries an opcode together with a code and any operands. The unit can do five things: step down to a child, step up to the parent, report the depth, form an octant number from three centre comparisons and step down with it, or step down only when the child is present in an 8-bit allocation mask. Each accepted request yields one registered response one cycle later. The response holds the resulting code, its depth, the octant that was used and an error flag. Whenever an operation is refused, the error flag is set and the code comes back as it went in. The code width is a parameter: 32 bits allows depth 10 and 64 bits allows depth 21.

Top module: `loccode_unit`

## Requirements
- R1: During and right after reset, `rsp_valid` is 0 and `req_ready` is 1.
- R2: Opcode 0 (descend) with a legal code below maximum depth returns `(code << 3) | req_octant`, error clear, in the cycle after acceptance.
- R3: Opcode 1 (ascend) returns `code >> 3` with error clear. On the root code 1 it sets the error flag and returns 1 unchanged.
- R4: Opcode 2 (depth) returns the code unchanged and a depth equal to floor(msb index / 3). For example, code 1 gives 0, code 0xF gives 1 and code 2^30 gives 10.
- R5: Opcode 3 forms the octant as {req_gt_z, req_gt_y, req_gt_x} (bit 2 top, bit 1 back, bit 0 right) and then descends as in R2. `rsp_octant` is the formed octant for opcode 3, `req_octant` for opcodes 0 and 4, and 0 otherwise.
- R6: Opcode 4 (masked descend) descends when bit `req_octant` of `req_child_mask` is 1. When that bit is 0 it sets the error flag and returns the code unchanged.
- R7: Any descending opcode (0, 3, 4) on a code whose depth is at least the maximum ((CODE_W-1)/3, which is 10 for 32 bits) sets the error flag and returns the code unchanged.
- R8: A zero code sets the error flag for every opcode and returns code 0 with depth 0.
- R9: Opcodes 5 to 7 set the error flag and return the code unchanged.
- R10: A request is accepted when `req_valid` and `req_ready` are both 1, and its response is valid on the next cycle. `req_ready` equals `!rsp_valid || rsp_ready`. A response held while `rsp_ready` is 0 stays stable.
- R11: `rsp_depth` is always the depth of `rsp_code` and never exceeds the maximum depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 3 | Operation select |
| req_code | input | CODE_W | Input locational code |
| req_octant | input | 3 | Octant for descend operations |
| req_gt_x | input | 1 | Position right of cell centre |
| req_gt_y | input | 1 | Position behind cell centre |
| req_gt_z | input | 1 | Position above cell centre |
| req_child_mask | input | 8 | Allocated-children mask, bit i for octant i |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer takes it this cycle |
| rsp_code | output | CODE_W | Resulting code |
| rsp_depth | output | DEP_W | Depth of rsp_code |
| rsp_octant | output | 3 | Octant used by the operation |
| rsp_err | output | 1 | Operation refused |

## Verification
Two functions can fall in the same cycle: draining a finished response and accepting the next request. The bench keeps `req_valid` high across consecutive cycles while `rsp_ready` is 1, so the second request is taken in the same edge that consumes the first result. It then checks that each result appears in turn, with no loss and no duplication. It also holds `rsp_ready` low with a second request waiting. It checks that the pending result stays frozen and that `req_ready` stays 0 until the consumer releases the response. At that point the drain and the new acceptance coincide.

// File: rtl/loccode_pkg.sv
package loccode_pkg;

   localparam int OCT_W = 3;
   localparam int N_OCT = 8;

   typedef enum logic [2:0] {
      OP_DESCEND   = 3'd0,
      OP_ASCEND    = 3'd1,
      OP_DEPTH     = 3'd2,
      OP_OCTANT    = 3'd3,
      OP_DESC_MASK = 3'd4
   } loccode_op_e;

   // deepest level a code of the given width can name (one marker bit)
   function automatic int max_depth(input int code_w);
      return (code_w - 1) / OCT_W;
   endfunction

   function automatic int depth_w(input int code_w);
      return $clog2(max_depth(code_w) + 1);
   endfunction

endpackage

// File: rtl/loccode_lod.sv
module loccode_lod #(
   parameter int W     = 32,
   parameter int IDX_W = $clog2(W)
) (
   input  logic [W-1:0]     vec,
   output logic [IDX_W-1:0] idx,
   output logic             found
);

   // highest set bit wins: later iterations overwrite earlier ones
   always_comb begin
      idx   = '0;
      found = 1'b0;
      for (int i = 0; i < W; i++) begin
         if (vec[i]) begin
            idx   = IDX_W'(i);
            found = 1'b1;
         end
      end
   end

endmodule

// File: rtl/loccode_div3.sv
module loccode_div3 #(
   parameter int IDX_W = 5,
   parameter int N     = 32,
   parameter int OUT_W = 4
) (
   input  logic [IDX_W-1:0] idx,
   output logic [OUT_W-1:0] quo
);

   logic [OUT_W-1:0] tbl [N];

   // constant quotient table, one entry per bit position
   generate
      for (genvar g = 0; g < N; g++) begin : g_tbl
         assign tbl[g] = OUT_W'(g / 3);
      end
   endgenerate

   assign quo = (int'(idx) < N) ? tbl[idx] : '0;

endmodule

// File: rtl/loccode_depth.sv
module loccode_depth #(
   parameter int CODE_W = 32,
   parameter int DEP_W  = 4
) (
   input  logic [CODE_W-1:0] code,
   output logic [DEP_W-1:0]  depth
);

   localparam int IDX_W = $clog2(CODE_W);

   logic [IDX_W-1:0] msb_idx;
   logic             nonzero;
   logic [DEP_W-1:0] quo;

   loccode_lod #(.W(CODE_W), .IDX_W(IDX_W)) u_lod (
      .vec   (code),
      .idx   (msb_idx),
      .found (nonzero)
   );

   loccode_div3 #(.IDX_W(IDX_W), .N(CODE_W), .OUT_W(DEP_W)) u_div3 (
      .idx (msb_idx),
      .quo (quo)
   );

   assign depth = nonzero ? quo : '0;

endmodule

// File: rtl/loccode_alu.sv
module loccode_alu
   import loccode_pkg::*;
#(
   parameter int CODE_W = 32
) (
   input  logic [2:0]        op,
   input  logic [CODE_W-1:0] code,
   input  logic [2:0]        octant,
   input  logic              gt_x,
   input  logic              gt_y,
   input  logic              gt_z,
   input  logic [N_OCT-1:0]  child_mask,
   output logic [CODE_W-1:0] res_code,
   output logic [2:0]        res_oct,
   output logic              res_err
);

   localparam int MAXD  = max_depth(CODE_W);
   localparam int LIM_SH = OCT_W * MAXD;

   logic              is_zero;
   logic              at_limit;
   logic              is_root;
   logic [2:0]        built_oct;
   logic [CODE_W-1:0] up_code;
   logic [CODE_W-1:0] down_req;
   logic [CODE_W-1:0] down_built;
   loccode_op_e       op_e;

   assign op_e      = loccode_op_e'(op);
   assign is_zero   = (code == '0);
   assign is_root   = (code == CODE_W'(1));
   // any bit at or above 3*MAXD means depth already at the limit
   assign at_limit  = ((code >> LIM_SH) != '0);
   assign built_oct = {gt_z, gt_y, gt_x};
   assign up_code   = code >> OCT_W;
   assign down_req  = {code[CODE_W-OCT_W-1:0], octant};
   assign down_built = {code[CODE_W-OCT_W-1:0], built_oct};

   always_comb begin
      res_code = code;
      res_oct  = '0;
      res_err  = 1'b0;
      unique case (op_e)
         OP_DESCEND: begin
            res_oct = octant;
            if (is_zero || at_limit) res_err = 1'b1;
            else                     res_code = down_req;
         end
         OP_ASCEND: begin
            if (is_zero || is_root) res_err = 1'b1;
            else                    res_code = up_code;
         end
         OP_DEPTH: begin
            res_err = is_zero;
         end
         OP_OCTANT: begin
            res_oct = built_oct;
            if (is_zero || at_limit) res_err = 1'b1;
            else                     res_code = down_built;
         end
         OP_DESC_MASK: begin
            res_oct = octant;
            if (is_zero || at_limit || !child_mask[octant]) res_err = 1'b1;
            else                                            res_code = down_req;
         end
         default: begin
            res_err = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/loccode_unit.sv
module loccode_unit
   import loccode_pkg::*;
#(
   parameter  int CODE_W = 32,
   localparam int DEP_W  = depth_w(CODE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_op,
   input  logic [CODE_W-1:0] req_code,
   input  logic [2:0]        req_octant,
   input  logic              req_gt_x,
   input  logic              req_gt_y,
   input  logic              req_gt_z,
   input  logic [7:0]        req_child_mask,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [CODE_W-1:0] rsp_code,
   output logic [DEP_W-1:0]  rsp_depth,
   output logic [2:0]        rsp_octant,
   output logic              rsp_err
);

   generate
      if (CODE_W < 7 || CODE_W > 64) begin : g_bad_width
         $error("loccode_unit: CODE_W must lie in 7..64");
      end
      if (N_OCT != 8) begin : g_bad_oct
         $error("loccode_unit: octant count must be 8");
      end
   endgenerate

   logic [CODE_W-1:0] alu_code;
   logic [2:0]        alu_oct;
   logic              alu_err;
   logic [DEP_W-1:0]  alu_depth;
   logic              accept;

   loccode_alu #(.CODE_W(CODE_W)) u_alu (
      .op         (req_op),
      .code       (req_code),
      .octant     (req_octant),
      .gt_x       (req_gt_x),
      .gt_y       (req_gt_y),
      .gt_z       (req_gt_z),
      .child_mask (req_child_mask),
      .res_code   (alu_code),
      .res_oct    (alu_oct),
      .res_err    (alu_err)
   );

   loccode_depth #(.CODE_W(CODE_W), .DEP_W(DEP_W)) u_depth (
      .code  (alu_code),
      .depth (alu_depth)
   );

   assign req_ready = !rsp_valid || rsp_ready;
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_code   <= '0;
         rsp_depth  <= '0;
         rsp_octant <= '0;
         rsp_err    <= 1'b0;
      end else begin
         if (accept) begin
            rsp_valid  <= 1'b1;
            rsp_code   <= alu_code;
            rsp_depth  <= alu_depth;
            rsp_octant <= alu_oct;
            rsp_err    <= alu_err;
         end else if (rsp_ready) begin
            rsp_valid  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/loccode_unit_chk.sv
module loccode_unit_chk
   import loccode_pkg::*;
#(
   parameter  int CODE_W = 32,
   localparam int DEP_W  = depth_w(CODE_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [2:0]        req_op,
   input logic [CODE_W-1:0] req_code,
   input logic [2:0]        req_octant,
   input logic [7:0]        req_child_mask,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [CODE_W-1:0] rsp_code,
   input logic [DEP_W-1:0]  rsp_depth,
   input logic              rsp_err
);

   localparam int MAXD = max_depth(CODE_W);
   localparam int LIM  = OCT_W * MAXD;

   logic acc;
   logic shallow;
   assign acc     = req_valid && req_ready;
   assign shallow = (req_code != '0) && ((req_code >> LIM) == '0);

   assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> rsp_valid);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code) && $stable(rsp_err)));

   assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |-> (rsp_valid && !rsp_ready));

   assert_descend_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_op == 3'd0 && shallow) |=>
         (!rsp_err && rsp_code == (($past(req_code) << 3) | CODE_W'($past(req_octant)))));

   assert_ascend_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_op == 3'd1 && req_code > CODE_W'(1)) |=>
         (!rsp_err && rsp_code == ($past(req_code) >> 3)));

   assert_root_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_op == 3'd1 && req_code == CODE_W'(1)) |=> (rsp_err && rsp_code == CODE_W'(1)));

   assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_op == 3'd4 && !req_child_mask[req_octant]) |=>
         (rsp_err && rsp_code == $past(req_code)));

   assert_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_code == '0) |=> (rsp_err && rsp_code == '0 && rsp_depth == '0));

   assert_depth_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (int'(rsp_depth) <= MAXD));

endmodule

bind loccode_unit loccode_unit_chk #(.CODE_W(CODE_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_ready      (req_ready),
   .req_op         (req_op),
   .req_code       (req_code),
   .req_octant     (req_octant),
   .req_child_mask (req_child_mask),
   .rsp_valid      (rsp_valid),
   .rsp_ready      (rsp_ready),
   .rsp_code       (rsp_code),
   .rsp_depth      (rsp_depth),
   .rsp_err        (rsp_err)
);

// File: tb/loccode_unit_tb.sv
module loccode_unit_tb;

   localparam int CW = 32;
   localparam int DW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [2:0]    req_op = '0;
   logic [CW-1:0] req_code = '0;
   logic [2:0]    req_octant = '0;
   logic          req_gt_x = 1'b0;
   logic          req_gt_y = 1'b0;
   logic          req_gt_z = 1'b0;
   logic [7:0]    req_child_mask = '0;
   logic          rsp_valid;
   logic          rsp_ready = 1'b1;
   logic [CW-1:0] rsp_code;
   logic [DW-1:0] rsp_depth;
   logic [2:0]    rsp_octant;
   logic          rsp_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   loccode_unit #(.CODE_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_code(req_code), .req_octant(req_octant),
      .req_gt_x(req_gt_x), .req_gt_y(req_gt_y), .req_gt_z(req_gt_z),
      .req_child_mask(req_child_mask), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_code(rsp_code), .rsp_depth(rsp_depth), .rsp_octant(rsp_octant),
      .rsp_err(rsp_err)
   );

   // depth by repeated 3-bit stripping
   function automatic int ref_depth(input logic [CW-1:0] c);
      int d = 0;
      logic [CW-1:0] v = c;
      while ((v >> 3) != '0) begin
         v = v >> 3;
         d++;
      end
      return d;
   endfunction

   task automatic check_rsp(input string tag, input logic [CW-1:0] ecode,
                            input bit eerr, input logic [2:0] eoct);
      int edep = ref_depth(ecode);
      checks++;
      if (rsp_valid !== 1'b1 || rsp_code !== ecode || rsp_err !== eerr ||
          rsp_octant !== eoct || int'(rsp_depth) != edep) begin
         fails++;
         $display("FAIL %s: got v=%0b code=%h err=%0b oct=%0d dep=%0d, exp v=1 code=%h err=%0b oct=%0d dep=%0d",
                  tag, rsp_valid, rsp_code, rsp_err, rsp_octant, rsp_depth,
                  ecode, eerr, eoct, edep);
      end
   endtask

   task automatic check_bit(input string tag, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0b exp %0b", tag, got, exp);
      end
   endtask

   task automatic drive(input logic [2:0] op, input logic [CW-1:0] code,
                        input logic [2:0] oct, input logic [2:0] gzyx,
                        input logic [7:0] mask);
      req_op = op; req_code = code; req_octant = oct;
      {req_gt_z, req_gt_y, req_gt_x} = gzyx;
      req_child_mask = mask; req_valid = 1'b1;
   endtask

   // one request, response checked the cycle after acceptance
   task automatic one(input string tag, input logic [2:0] op, input logic [CW-1:0] code,
                      input logic [2:0] oct, input logic [2:0] gzyx, input logic [7:0] mask,
                      input logic [CW-1:0] ecode, input bit eerr, input logic [2:0] eoct);
      @(negedge clk);
      drive(op, code, oct, gzyx, mask);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check_rsp(tag, ecode, eerr, eoct);
   endtask

   task automatic t_reset;
      check_bit("R1 rsp_valid in reset", rsp_valid, 1'b0);
      check_bit("R1 req_ready in reset", req_ready, 1'b1);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check_bit("R1 rsp_valid after reset", rsp_valid, 1'b0);
      check_bit("R1 req_ready after reset", req_ready, 1'b1);
   endtask

   task automatic t_descend;
      one("R2 root oct5", 3'd0, 32'h1, 3'd5, 3'd0, 8'h0, 32'hD, 1'b0, 3'd5);
      one("R2 depth1 oct0", 3'd0, 32'hD, 3'd0, 3'd0, 8'h0, 32'h68, 1'b0, 3'd0);
      one("R2 R11 to depth10", 3'd0, 32'h0800_0000, 3'd7, 3'd0, 8'h0, 32'h4000_0007, 1'b0, 3'd7);
   endtask

   task automatic t_ascend;
      one("R3 parent", 3'd1, 32'h68, 3'd0, 3'd0, 8'h0, 32'hD, 1'b0, 3'd0);
      one("R3 root", 3'd1, 32'h1, 3'd0, 3'd0, 8'h0, 32'h1, 1'b1, 3'd0);
   endtask

   task automatic t_depth;
      one("R4 code1", 3'd2, 32'h1, 3'd0, 3'd0, 8'h0, 32'h1, 1'b0, 3'd0);
      one("R4 code F", 3'd2, 32'hF, 3'd0, 3'd0, 8'h0, 32'hF, 1'b0, 3'd0);
      one("R4 code 2^30", 3'd2, 32'h4000_0000, 3'd0, 3'd0, 8'h0, 32'h4000_0000, 1'b0, 3'd0);
      one("R4 code 7FFFFFFF", 3'd2, 32'h7FFF_FFFF, 3'd0, 3'd0, 8'h0, 32'h7FFF_FFFF, 1'b0, 3'd0);
   endtask

   task automatic t_octant;
      one("R5 top-right-front", 3'd3, 32'h1, 3'd2, 3'b101, 8'h0, 32'hD, 1'b0, 3'd5);
      one("R5 bottom-left-front", 3'd3, 32'hD, 3'd6, 3'b000, 8'h0, 32'h68, 1'b0, 3'd0);
      one("R5 top-right-back", 3'd3, 32'h1, 3'd0, 3'b111, 8'h0, 32'hF, 1'b0, 3'd7);
   endtask

   task automatic t_mask;
      one("R6 bit set", 3'd4, 32'h1, 3'd5, 3'd0, 8'h20, 32'hD, 1'b0, 3'd5);
      one("R6 bit clear", 3'd4, 32'h1, 3'd5, 3'd0, 8'hDF, 32'h1, 1'b1, 3'd5);
   endtask

   task automatic t_limit;
      one("R7 descend at max", 3'd0, 32'h4000_0000, 3'd1, 3'd0, 8'h0, 32'h4000_0000, 1'b1, 3'd1);
      one("R7 octant at max", 3'd3, 32'h4000_0000, 3'd0, 3'b011, 8'h0, 32'h4000_0000, 1'b1, 3'd3);
      one("R7 masked at max", 3'd4, 32'h4000_0000, 3'd2, 3'd0, 8'hFF, 32'h4000_0000, 1'b1, 3'd2);
   endtask

   task automatic t_zero;
      for (int op = 0; op < 5; op++)
         one($sformatf("R8 zero code op%0d", op), 3'(op), 32'h0, 3'd0, 3'd0, 8'hFF,
             32'h0, 1'b1, 3'd0);
   endtask

   task automatic t_badop;
      one("R9 op6", 3'd6, 32'hD, 3'd3, 3'd0, 8'h0, 32'hD, 1'b1, 3'd0);
      one("R9 op7", 3'd7, 32'h68, 3'd3, 3'd0, 8'h0, 32'h68, 1'b1, 3'd0);
   endtask

   task automatic t_back_to_back;
      @(negedge clk);
      drive(3'd0, 32'h1, 3'd3, 3'd0, 8'h0);
      @(posedge clk);
      @(negedge clk);
      check_rsp("R10 first of pair", 32'hB, 1'b0, 3'd3);
      check_bit("R10 ready while draining", req_ready, 1'b1);
      drive(3'd1, 32'h68, 3'd0, 3'd0, 8'h0);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check_rsp("R10 second of pair", 32'hD, 1'b0, 3'd0);
      @(negedge clk);
      check_bit("R10 drained", rsp_valid, 1'b0);
   endtask

   task automatic t_backpressure;
      @(negedge clk);
      rsp_ready = 1'b0;
      drive(3'd2, 32'h40, 3'd0, 3'd0, 8'h0);
      @(posedge clk);
      @(negedge clk);
      drive(3'd0, 32'h40, 3'd1, 3'd0, 8'h0);
      check_rsp("R10 held result", 32'h40, 1'b0, 3'd0);
      check_bit("R10 ready low when held", req_ready, 1'b0);
      @(posedge clk);
      @(negedge clk);
      check_rsp("R10 still held", 32'h40, 1'b0, 3'd0);
      check_bit("R10 still not ready", req_ready, 1'b0);
      rsp_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check_rsp("R10 waiting request taken", 32'h201, 1'b0, 3'd1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset;
      t_descend;
      t_ascend;
      t_depth;
      t_octant;
      t_mask;
      t_limit;
      t_zero;
      t_badop;
      t_back_to_back;
      t_backpressure;
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule